// File: doc/BRIEF.md
# Nibble-Serial SIMD Processing Element

This block is one lane of a lockstep SIMD array. It keeps a private file of 48 words, each 32 bits wide. It carries out 32-bit integer operations through an ALU only four bits wide, working through one nibble per clock from the least significant nibble upward. A flip-flop carries the carry or borrow from each nibble step into the next one.

A shared controller drives the same instruction into every lane at once. The instruction holds an opcode, two source indices, a destination index and a 32-bit broadcast constant. Each lane has an enable input. When the enable is low, the lane still computes the result but does not commit it, so lanes can be masked out of an instruction. Alongside the nibble ALU, a one-bit logic unit folds each result nibble into a zero indication. The final carry-out and the zero indication are kept as status bits.

A single-cycle start pulse launches an instruction. The lane is busy for eight nibble steps. It then raises done for one cycle, and it accepts the next instruction in that same cycle.

Top module: `nibble_pe`

## Requirements
- R1: After reset, busy, done, result, carry_flag and zero_flag are 0, and every register reads as zero.
- R2: A start seen at a clock edge while busy is low captures opcode, src_a, src_b, dst, lane_en and imm. Busy is high from the next cycle onward.
- R3: Done is high for exactly one cycle, in the cycle after the eighth clock edge that follows the accepting edge. Busy falls in that same cycle.
- R4: A start that arrives while busy is high is ignored completely, including any different fields that come with it. A start given in the done cycle is accepted.
- R5: Opcode 0 (add) produces src_a + src_b modulo 2^32, with the carry passed across all nibbles. carry_flag takes the carry out of bit 31.
- R6: Opcode 1 (subtract) produces src_a - src_b modulo 2^32. carry_flag is 1 when no borrow occurs, that is when src_a >= src_b unsigned.
- R7: Opcodes 2, 3 and 4 produce the bitwise AND, OR and XOR of the two sources, and they set carry_flag to 0.
- R8: Opcodes 5 and 7 copy src_a. Opcode 6 loads imm. All three set carry_flag to 0.
- R9: zero_flag is set to 1 when the 32-bit result is zero and to 0 otherwise.
- R10: When lane_en was captured low, the destination register, carry_flag and zero_flag are left unchanged. Result still shows the computed word.
- R11: Register indices 48 to 63 read as zero, and writes to them are discarded.
- R12: Result holds the completed word from the done cycle until the next instruction is accepted. carry_flag and zero_flag change only at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction launch pulse |
| opcode | input | 3 | Operation code |
| src_a | input | 6 | First source register index |
| src_b | input | 6 | Second source register index |
| dst | input | 6 | Destination register index |
| lane_en | input | 1 | Write-back enable for this lane |
| imm | input | 32 | Broadcast constant used by the load opcode |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Computed word, valid from done |
| carry_flag | output | 1 | Final carry-out of the last committed instruction |
| zero_flag | output | 1 | Zero indication of the last committed instruction |

## Verification
The bench builds its operands so that a carry ripples through all eight nibbles. If the carry flip-flop were dropped or reset between steps, the sum 0x89ABCDEF + 0x76543211 would not wrap to zero with carry_flag and zero_flag set. The subtract cases cover both borrow and no-borrow, so an inverted borrow sense shows up in carry_flag. Masked instructions and writes to indices 48 and above are read back through later copy operations, and a design that ignored the mask or the index limit would return the overwritten value. A second start sent in the middle of an operation checks that neither the latched fields nor the step count are disturbed, and back-to-back starts in the done cycle check that the pipeline gap is zero and that a value written one step earlier is read back correctly.

// File: rtl/nibble_pe_pkg.sv
package nibble_pe_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_MOV = 3'd5,
    OP_LDI = 3'd6,
    OP_CPY = 3'd7
  } pe_op_e;
endpackage

// File: rtl/nibble_pe_rf.sv
module nibble_pe_rf #(
  parameter int WORD_W = 32,
  parameter int REGS   = 48,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [WORD_W-1:0] rd_a_word,
  output logic [WORD_W-1:0] rd_b_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word
);
  logic [WORD_W-1:0] mem [REGS];

  // Reads outside the implemented range return zero.
  always_comb begin
    rd_a_word = (int'(rd_a_idx) < REGS) ? mem[rd_a_idx] : '0;
    rd_b_word = (int'(rd_b_idx) < REGS) ? mem[rd_b_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < REGS)) begin
      mem[wr_idx] <= wr_word;
    end
  end
endmodule

// File: rtl/nibble_pe_alu.sv
module nibble_pe_alu
  import nibble_pe_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  pe_op_e           op,
  input  logic [NIB_W-1:0] a,
  input  logic [NIB_W-1:0] b,
  input  logic             cin,
  output logic [NIB_W-1:0] y,
  output logic             cout
);
  logic [NIB_W-1:0] b_eff;
  logic [NIB_W:0]   sum;

  always_comb begin
    b_eff = (op == OP_SUB) ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{NIB_W{1'b0}}, cin};
    case (op)
      OP_ADD, OP_SUB: begin y = sum[NIB_W-1:0]; cout = sum[NIB_W]; end
      OP_AND:         begin y = a & b;          cout = 1'b0;       end
      OP_OR:          begin y = a | b;          cout = 1'b0;       end
      OP_XOR:         begin y = a ^ b;          cout = 1'b0;       end
      default:        begin y = a;              cout = 1'b0;       end
    endcase
  end
endmodule

// File: rtl/nibble_pe_seq.sv
module nibble_pe_seq #(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign accept    = start & ~busy_q;
  assign step_en   = busy_q;
  assign last_step = busy_q & (cnt_q == LAST);
  assign busy      = busy_q;
  assign done      = done_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  // Checker-only cycle counter: edges spent busy since the accepting edge.
  logic [CW:0] chk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_q <= '0;
    else if (accept) chk_q <= '0;
    else if (busy_q) chk_q <= chk_q + 1'b1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (int'(chk_q) == STEPS)) else $error("done latency"); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R3

  AST_BUSY_CLEAR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q) else $error("busy during done"); // R3

  AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != LAST)) |=> (busy_q && (cnt_q == $past(cnt_q) + 1'b1)))
    else $error("step count disturbed"); // R4
endmodule

// File: rtl/nibble_pe.sv
module nibble_pe
  import nibble_pe_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NIB_W  = 4,
  parameter int REGS   = 48,
  parameter int IDX_W  = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        opcode,
  input  logic [IDX_W-1:0]  src_a,
  input  logic [IDX_W-1:0]  src_b,
  input  logic [IDX_W-1:0]  dst,
  input  logic              lane_en,
  input  logic [WORD_W-1:0] imm,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic              carry_flag,
  output logic              zero_flag
);
  localparam int STEPS = WORD_W / NIB_W;

  logic accept, step_en, last_step;
  logic [WORD_W-1:0] rd_a_word, rd_b_word;
  logic [NIB_W-1:0]  alu_y;
  logic              alu_co;

  pe_op_e            op_q, op_d;
  logic              en_q, en_d;
  logic [IDX_W-1:0]  dst_q, dst_d;
  logic [WORD_W-1:0] a_q, a_d, b_q, b_d, res_q, res_d;
  logic              cy_q, cy_d;
  logic              zacc_q, zacc_d;
  logic              cf_q, cf_d, zf_q, zf_d;
  logic              rf_we;

  nibble_pe_seq #(.STEPS(STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .step_en(step_en), .last_step(last_step),
    .busy(busy), .done(done)
  );

  nibble_pe_rf #(.WORD_W(WORD_W), .REGS(REGS), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(src_a), .rd_b_idx(src_b),
    .rd_a_word(rd_a_word), .rd_b_word(rd_b_word),
    .wr_en(rf_we), .wr_idx(dst_q), .wr_word(res_d)
  );

  nibble_pe_alu #(.NIB_W(NIB_W)) u_alu (
    .op(op_q), .a(a_q[NIB_W-1:0]), .b(b_q[NIB_W-1:0]), .cin(cy_q),
    .y(alu_y), .cout(alu_co)
  );

  assign rf_we = step_en & last_step & en_q;

  always_comb begin
    op_d   = op_q;
    en_d   = en_q;
    dst_d  = dst_q;
    a_d    = a_q;
    b_d    = b_q;
    res_d  = res_q;
    cy_d   = cy_q;
    zacc_d = zacc_q;
    cf_d   = cf_q;
    zf_d   = zf_q;
    if (accept) begin
      op_d   = pe_op_e'(opcode);
      en_d   = lane_en;
      dst_d  = dst;
      a_d    = (opcode == OP_LDI) ? imm : rd_a_word;
      b_d    = rd_b_word;
      cy_d   = (opcode == OP_SUB);
      zacc_d = 1'b1;
    end else if (step_en) begin
      a_d    = a_q >> NIB_W;
      b_d    = b_q >> NIB_W;
      res_d  = {alu_y, res_q[WORD_W-1:NIB_W]};
      cy_d   = alu_co;
      zacc_d = zacc_q & (alu_y == '0);   // one-bit logic unit
      if (last_step && en_q) begin
        cf_d = alu_co;
        zf_d = zacc_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ADD;
      en_q   <= 1'b0;
      dst_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      res_q  <= '0;
      cy_q   <= 1'b0;
      zacc_q <= 1'b0;
      cf_q   <= 1'b0;
      zf_q   <= 1'b0;
    end else begin
      op_q   <= op_d;
      en_q   <= en_d;
      dst_q  <= dst_d;
      a_q    <= a_d;
      b_q    <= b_d;
      res_q  <= res_d;
      cy_q   <= cy_d;
      zacc_q <= zacc_d;
      cf_q   <= cf_d;
      zf_q   <= zf_d;
    end
  end

  assign result     = res_q;
  assign carry_flag = cf_q;
  assign zero_flag  = zf_q;

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(dst_q) && $stable(en_q)))
    else $error("latched fields changed"); // R4

  AST_FLAGS_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(carry_flag) && $stable(zero_flag)))
    else $error("flags moved outside completion"); // R12

  AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && $past(!busy)) |-> $stable(result))
    else $error("result changed while idle"); // R12

  AST_MASK_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !en_q) |-> ($stable(carry_flag) && $stable(zero_flag)))
    else $error("masked lane changed flags"); // R10
endmodule

// File: tb/nibble_pe_bench.sv
`timescale 1ns/1ps
module nibble_pe_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opcode = '0;
  logic [5:0]  src_a = '0, src_b = '0, dst = '0;
  logic        lane_en = 1'b0;
  logic [31:0] imm = '0;
  logic        busy, done, carry_flag, zero_flag;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  nibble_pe u_nibble_pe (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .dst(dst), .lane_en(lane_en), .imm(imm),
    .busy(busy), .done(done), .result(result),
    .carry_flag(carry_flag), .zero_flag(zero_flag)
  );

  // Behavioural reference model
  logic [31:0] m_rf [64];
  bit          m_busy, m_done, m_en, m_cf, m_zf, m_ncf;
  int          m_left;
  logic [31:0] m_res;
  logic [2:0]  m_op;
  logic [5:0]  m_dst;

  function automatic logic [31:0] m_read(input logic [5:0] i);
    return (i < 6'd48) ? m_rf[i] : 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m_rf[i] = '0;
      m_busy = 0; m_done = 0; m_en = 0; m_cf = 0; m_zf = 0; m_ncf = 0;
      m_left = 0; m_res = '0; m_op = '0; m_dst = '0;
    end else begin
      bit acc;
      logic [31:0] a, b;
      logic [32:0] s;
      acc = start && !m_busy;
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_done = 1;
          if (m_en) begin
            if (m_dst < 6'd48) m_rf[m_dst] = m_res;
            m_cf = m_ncf;
            m_zf = (m_res == 32'h0);
          end
        end
      end
      if (acc) begin
        a = (opcode == 3'd6) ? imm : m_read(src_a);
        b = m_read(src_b);
        m_op = opcode; m_en = lane_en; m_dst = dst;
        m_busy = 1; m_left = 8;
        case (opcode)
          3'd0: begin s = {1'b0, a} + {1'b0, b}; m_res = s[31:0]; m_ncf = s[32]; end
          3'd1: begin m_res = a - b; m_ncf = (a >= b); end
          3'd2: begin m_res = a & b; m_ncf = 0; end
          3'd3: begin m_res = a | b; m_ncf = 0; end
          3'd4: begin m_res = a ^ b; m_ncf = 0; end
          default: begin m_res = a; m_ncf = 0; end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2, 3'd3, 3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R2", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R3", 32'(done), 32'(m_done));
      chk(carry_flag == m_cf, m_done ? op_tag(m_op) : "R12", 32'(carry_flag), 32'(m_cf));
      chk(zero_flag == m_zf, "R9", 32'(zero_flag), 32'(m_zf));
      if (m_done) chk(result == m_res, op_tag(m_op), result, m_res);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog R3 actual=%0d expected<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Issue one instruction at a negedge, return at the negedge of its done cycle
  task automatic issue(input logic [2:0] op, input logic [5:0] a, input logic [5:0] b,
                       input logic [5:0] d, input bit en, input logic [31:0] k);
    opcode = op; src_a = a; src_b = b; dst = d; lane_en = en; imm = k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
  endtask

  initial begin
    logic [31:0] keep;
    bit kc, kz;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 32'h0);
    chk(result == 32'h0, "R1", result, 32'h0);
    chk(carry_flag == 1'b0 && zero_flag == 1'b0, "R1", {carry_flag, zero_flag}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(3'd5, 6'd3, 6'd0, 6'd10, 1, 32'h0);
    chk(result == 32'h0, "R1", result, 32'h0);
    issue(3'd7, 6'd47, 6'd0, 6'd11, 1, 32'h0);
    chk(result == 32'h0, "R1", result, 32'h0);

    // Loads and full-length carry ripple
    issue(3'd6, 6'd0, 6'd0, 6'd1, 1, 32'h89AB_CDEF);
    issue(3'd6, 6'd0, 6'd0, 6'd2, 1, 32'h7654_3211);
    issue(3'd0, 6'd1, 6'd2, 6'd3, 1, 32'h0);
    chk(result == 32'h0 && carry_flag && zero_flag, "R5", {carry_flag, zero_flag, result[29:0]}, 32'hC000_0000);
    chk(zero_flag == 1'b1, "R9", 32'(zero_flag), 32'h1);
    issue(3'd6, 6'd0, 6'd0, 6'd4, 1, 32'h0000_000F);
    issue(3'd6, 6'd0, 6'd0, 6'd5, 1, 32'h0000_0001);
    issue(3'd0, 6'd4, 6'd5, 6'd6, 1, 32'h0);
    chk(result == 32'h10 && !carry_flag, "R5", result, 32'h10);

    // Subtract with and without borrow, and equal operands
    issue(3'd1, 6'd5, 6'd4, 6'd7, 1, 32'h0);
    chk(result == 32'hFFFF_FFF2 && !carry_flag, "R6", result, 32'hFFFF_FFF2);
    issue(3'd1, 6'd4, 6'd5, 6'd8, 1, 32'h0);
    chk(result == 32'hE && carry_flag, "R6", result, 32'hE);
    issue(3'd1, 6'd1, 6'd1, 6'd9, 1, 32'h0);
    chk(zero_flag && carry_flag, "R9", {carry_flag, zero_flag}, 32'h3);

    // Bitwise ops and copies
    issue(3'd2, 6'd1, 6'd2, 6'd12, 1, 32'h0);
    issue(3'd3, 6'd1, 6'd2, 6'd13, 1, 32'h0);
    issue(3'd4, 6'd1, 6'd7, 6'd14, 1, 32'h0);
    chk(result == (32'h89AB_CDEF ^ 32'hFFFF_FFF2), "R7", result, 32'h89AB_CDEF ^ 32'hFFFF_FFF2);
    issue(3'd5, 6'd14, 6'd0, 6'd15, 1, 32'h0);
    issue(3'd7, 6'd15, 6'd0, 6'd16, 1, 32'h0);
    chk(result == (32'h89AB_CDEF ^ 32'hFFFF_FFF2), "R8", result, 32'h89AB_CDEF ^ 32'hFFFF_FFF2);

    // Result held while idle
    keep = result;
    repeat (4) begin
      @(negedge clk);
      chk(result == keep, "R12", result, keep);
    end

    // Masked lane: nothing committed, result still shown
    kc = carry_flag; kz = zero_flag;
    issue(3'd6, 6'd0, 6'd0, 6'd1, 0, 32'h1234_5678);
    chk(result == 32'h1234_5678, "R10", result, 32'h1234_5678);
    issue(3'd1, 6'd5, 6'd4, 6'd2, 0, 32'h0);
    chk(carry_flag == kc && zero_flag == kz, "R10", {carry_flag, zero_flag}, {kc, kz});
    issue(3'd5, 6'd1, 6'd0, 6'd20, 1, 32'h0);
    chk(result == 32'h89AB_CDEF, "R10", result, 32'h89AB_CDEF);
    issue(3'd5, 6'd2, 6'd0, 6'd21, 1, 32'h0);
    chk(result == 32'h7654_3211, "R10", result, 32'h7654_3211);

    // Out-of-range indices
    issue(3'd6, 6'd0, 6'd0, 6'd50, 1, 32'hCAFE_F00D);
    issue(3'd5, 6'd50, 6'd0, 6'd22, 1, 32'h0);
    chk(result == 32'h0, "R11", result, 32'h0);
    issue(3'd0, 6'd1, 6'd63, 6'd23, 1, 32'h0);
    chk(result == 32'h89AB_CDEF, "R11", result, 32'h89AB_CDEF);

    // Start during an operation is ignored
    @(negedge clk);
    opcode = 3'd0; src_a = 6'd1; src_b = 6'd2; dst = 6'd30; lane_en = 1; imm = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    opcode = 3'd6; dst = 6'd31; imm = 32'hDEAD_BEEF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    chk(result == 32'h0, "R4", result, 32'h0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R4", 32'(busy), 32'h0);
    issue(3'd5, 6'd31, 6'd0, 6'd40, 1, 32'h0);
    chk(result == 32'h0, "R4", result, 32'h0);

    // Back-to-back in the done cycle with read-after-write
    issue(3'd6, 6'd0, 6'd0, 6'd33, 1, 32'h0000_0100);
    issue(3'd0, 6'd33, 6'd33, 6'd34, 1, 32'h0);
    chk(result == 32'h200, "R4", result, 32'h200);
    issue(3'd1, 6'd34, 6'd33, 6'd35, 1, 32'h0);
    chk(result == 32'h100 && carry_flag, "R6", result, 32'h100);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule